// File: doc/BRIEF.md
# Mini UART Register Front End

This block is the software-visible side of a small UART. A processor reaches it through a 32-bit word-access bus port. The port carries a select, a write flag, a byte address and write data, and returns read data in the same cycle. Received bytes arrive on a valid/ready byte input and are held in a circular receive queue until software reads the data register. Writing the data register sends the byte straight out on a one-cycle transmit strobe. The transmitter is treated as always idle, so it never holds anything back.

Status words are fixed constants with the live queue state merged in. Interrupt identification is prioritised by hand, with receive taking precedence over transmit. A single level interrupt output is raised when an enabled source is pending. Because the transmit path drains instantly, the transmit source is pending for as long as it is enabled.

The line control, modem control, modem status, scratch and baud registers hold no state. They read as zero and ignore writes. Any offset outside the map, including one that is not word aligned, behaves the same way.

Top module: `muart_regs`

## Requirements
- R1: A synchronous active-high `rst` empties the receive queue, moves its head to slot 0 and clears both interrupt-enable bits. After reset `irq` is low.
- R2: A write to the interrupt-enable register at offset 0x44 keeps only write-data bits 1 (transmit) and 0 (receive). A read of that register returns those two bits ORed with 0xC0.
- R3: The receive source is pending when enable bit 0 is set and the queue holds at least one byte. The transmit source is pending whenever enable bit 1 is set. `irq` is high exactly when either source is pending. A read of offset 0x00 returns 1 when `irq` is high and 0 otherwise.
- R4: A read of the identify register at offset 0x48 returns 0xC0, plus 0x4 when the queue is non-empty or 0x2 when it is empty, plus bit 0 set when no source is pending.
- R5: A write to offset 0x48 with write-data bit 1 set empties the queue in the next cycle. During that write cycle `rx_ready` is low, so no byte is accepted in that cycle.
- R6: A read of the line-status register at offset 0x54 returns 0x60, with bit 0 set when the queue is non-empty.
- R7: A read of the extended-status register at offset 0x64 returns 0x30E. When the queue is non-empty, bit 0 is also set and the fill count is placed from bit 16 upward.
- R8: Offset 0x04 always reads 1 and offset 0x60 always reads 0x3. Offsets 0x4C, 0x50, 0x58, 0x5C and 0x68 read 0, as does every unmapped or misaligned offset. Writes to any of these offsets change no state.
- R9: A read of the data register at offset 0x40 returns the byte at the queue head in bits 7:0 and advances the head by one, wrapping at the depth. A read while the queue is empty returns the stale head slot and changes nothing.
- R10: `rx_ready` is high while the fill count is below DEPTH. Each accepted byte is stored at head plus count, modulo DEPTH, so bytes leave in arrival order.
- R11: A write to offset 0x40 drives `tx_strobe` high for that cycle, with `tx_data` equal to write-data bits 7:0. No other access raises `tx_strobe`.
- R12: When a byte is accepted in the same cycle as a data read of a non-empty queue, the fill count stays the same and both the push and the pop take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle, zero when no read is in progress |
| rx_data | input | DW | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Received byte can be accepted |
| tx_data | output | DW | Byte to transmit |
| tx_strobe | output | 1 | One-cycle transmit pulse |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with DEPTH set to 4. With that depth, the full queue, the rejected fifth byte and several head wrap-arounds are reached within a few dozen cycles. The small depth also places the full-count value in the extended-status field and exercises a simultaneous push and pop near the wrap point. The remaining parameters keep their defaults, so the bus and byte widths are the ones a real integration uses.

// File: rtl/muart_pkg.sv
`timescale 1ns/1ps
package muart_pkg;
  localparam logic [7:0] OFS_IRQSUM = 8'h00;
  localparam logic [7:0] OFS_ENAB   = 8'h04;
  localparam logic [7:0] OFS_DATA   = 8'h40;
  localparam logic [7:0] OFS_IEN    = 8'h44;
  localparam logic [7:0] OFS_IID    = 8'h48;
  localparam logic [7:0] OFS_LCTL   = 8'h4C;
  localparam logic [7:0] OFS_MCTL   = 8'h50;
  localparam logic [7:0] OFS_LSTAT  = 8'h54;
  localparam logic [7:0] OFS_MSTAT  = 8'h58;
  localparam logic [7:0] OFS_SCR    = 8'h5C;
  localparam logic [7:0] OFS_XCTL   = 8'h60;
  localparam logic [7:0] OFS_XSTAT  = 8'h64;
  localparam logic [7:0] OFS_BAUD   = 8'h68;

  // slot index base+off folded into [0, depth)
  function automatic int wrap_add(input int base, input int off, input int depth);
    int s;
    s = base + off;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  function automatic logic [31:0] iid_word(input logic nonempty, input logic pending);
    logic [31:0] w;
    w = 32'hC0 | (nonempty ? 32'h4 : 32'h2);
    if (!pending) w = w | 32'h1;
    return w;
  endfunction

  function automatic logic [31:0] lstat_word(input logic nonempty);
    return 32'h60 | {31'd0, nonempty};
  endfunction

  function automatic logic [31:0] xstat_word(input logic [15:0] fill);
    logic [31:0] w;
    w = 32'h30E;
    if (fill != 16'd0) w = w | 32'h1 | {fill, 16'd0};
    return w;
  endfunction
endpackage

// File: rtl/muart_rx_fifo.sv
`timescale 1ns/1ps
module muart_rx_fifo import muart_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  input  logic          flush,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count,
  output logic [PW-1:0] head,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] tail_slot;
  logic [PW-1:0] head_nxt;
  logic          pop_eff;

  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign pop_eff   = pop && !empty;
  assign tail_slot = PW'(wrap_add(int'(head), int'(count), DEPTH));
  assign head_nxt  = PW'(wrap_add(int'(head), 1, DEPTH));
  assign head_data = mem[head];

  always_ff @(posedge clk) begin
    if (push) mem[tail_slot] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      head  <= '0;
    end else begin
      if (pop_eff) head <= head_nxt;
      if (flush) count <= '0;
      else count <= count + CW'(push) - CW'(pop_eff);
    end
  end
endmodule

// File: rtl/muart_irq.sv
`timescale 1ns/1ps
module muart_irq (
  input  logic       clk,
  input  logic       rst,
  input  logic       ien_wr,
  input  logic [1:0] ien_bits,
  input  logic       nonempty,
  output logic [1:0] ier,
  output logic       rx_pend,
  output logic       tx_pend,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (rst) ier <= 2'b00;
    else if (ien_wr) ier <= ien_bits;
  end

  assign rx_pend = ier[0] && nonempty;
  assign tx_pend = ier[1];
  assign irq     = rx_pend || tx_pend;
endmodule

// File: rtl/muart_rdmux.sv
`timescale 1ns/1ps
module muart_rdmux import muart_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DW     = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     head_data,
  input  logic [15:0]       fill,
  input  logic [1:0]        ier,
  input  logic              pending,
  output logic [31:0]       rdata
);
  logic nonempty;
  assign nonempty = (fill != 16'd0);

  always_comb begin
    rdata = 32'd0;
    if (addr == ADDR_W'(OFS_IRQSUM))     rdata = {31'd0, pending};
    else if (addr == ADDR_W'(OFS_ENAB))  rdata = 32'd1;
    else if (addr == ADDR_W'(OFS_DATA))  rdata = 32'(head_data);
    else if (addr == ADDR_W'(OFS_IEN))   rdata = 32'hC0 | {30'd0, ier};
    else if (addr == ADDR_W'(OFS_IID))   rdata = iid_word(nonempty, pending);
    else if (addr == ADDR_W'(OFS_LSTAT)) rdata = lstat_word(nonempty);
    else if (addr == ADDR_W'(OFS_XCTL))  rdata = 32'h3;
    else if (addr == ADDR_W'(OFS_XSTAT)) rdata = xstat_word(fill);
  end
endmodule

// File: rtl/muart_regs.sv
`timescale 1ns/1ps
module muart_regs import muart_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [DW-1:0]     tx_data,
  output logic              tx_strobe,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // named events, also watched by the checker
  logic          rd_evt, wr_evt;
  logic          pop_req, pop_evt, push_evt, flush_evt, ien_wr;
  logic [CW-1:0] fifo_count;
  logic [PW-1:0] fifo_head;
  logic [DW-1:0] head_data;
  logic          fifo_full, fifo_empty;
  logic [1:0]    ier_q;
  logic          rx_pend, tx_pend;
  logic [31:0]   mux_rdata;

  assign rd_evt    = bus_sel && !bus_wr;
  assign wr_evt    = bus_sel && bus_wr;
  assign pop_req   = rd_evt && (bus_addr == ADDR_W'(OFS_DATA));
  assign flush_evt = wr_evt && (bus_addr == ADDR_W'(OFS_IID)) && bus_wdata[1];
  assign ien_wr    = wr_evt && (bus_addr == ADDR_W'(OFS_IEN));
  assign rx_ready  = !fifo_full && !flush_evt;
  assign push_evt  = rx_valid && rx_ready;
  assign pop_evt   = pop_req && !fifo_empty;

  assign tx_strobe = wr_evt && (bus_addr == ADDR_W'(OFS_DATA));
  assign tx_data   = bus_wdata[DW-1:0];

  muart_rx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst(rst),
    .push(push_evt), .wdata(rx_data),
    .pop(pop_req), .flush(flush_evt),
    .head_data(head_data), .count(fifo_count), .head(fifo_head),
    .full(fifo_full), .empty(fifo_empty)
  );

  muart_irq u_irq (
    .clk(clk), .rst(rst),
    .ien_wr(ien_wr), .ien_bits(bus_wdata[1:0]),
    .nonempty(!fifo_empty),
    .ier(ier_q), .rx_pend(rx_pend), .tx_pend(tx_pend), .irq(irq)
  );

  muart_rdmux #(.ADDR_W(ADDR_W), .DW(DW)) u_rdmux (
    .addr(bus_addr), .head_data(head_data),
    .fill(16'(fifo_count)), .ier(ier_q),
    .pending(irq), .rdata(mux_rdata)
  );

  assign bus_rdata = rd_evt ? mux_rdata : 32'd0;
endmodule

// File: rtl/muart_regs_chk.sv
`timescale 1ns/1ps
module muart_regs_chk import muart_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [CW-1:0]     fifo_count,
  input logic [PW-1:0]     fifo_head,
  input logic              push_evt,
  input logic              pop_req,
  input logic              pop_evt,
  input logic              flush_evt,
  input logic              rx_ready,
  input logic              irq,
  input logic [1:0]        ier_q,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata
);
  assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CW'(DEPTH));

  assert_full_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    (fifo_count == CW'(DEPTH)) |-> !rx_ready);

  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (rst)
    flush_evt |=> (fifo_count == '0));

  assert_tx_irq_R3: assert property (@(posedge clk) disable iff (rst)
    ier_q[1] |-> irq);

  assert_quiet_irq_R3: assert property (@(posedge clk) disable iff (rst)
    (ier_q == 2'b00) |-> !irq);

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (rst)
    (pop_req && fifo_count == '0) |=> $stable(fifo_head));

  assert_push_pop_R12: assert property (@(posedge clk) disable iff (rst)
    (push_evt && pop_evt) |=> (fifo_count == $past(fifo_count)));

  assert_ien_read_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_IEN)) |->
      (bus_rdata[31:2] == 30'h30));
endmodule

bind muart_regs muart_regs_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .fifo_count(fifo_count), .fifo_head(fifo_head),
  .push_evt(push_evt), .pop_req(pop_req), .pop_evt(pop_evt),
  .flush_evt(flush_evt), .rx_ready(rx_ready), .irq(irq), .ier_q(ier_q),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata)
);

// File: tb/sim_muart_regs.sv
`timescale 1ns/1ps
module sim_muart_regs;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [7:0]  rx_data = 8'h0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_strobe;
  logic        irq;

  always #4 clk = ~clk;

  muart_regs #(.DEPTH(D)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_strobe(tx_strobe), .irq(irq)
  );

  // behavioural reference state
  int m_q[$];
  int m_slot[D];
  bit m_known[D];
  int m_head = 0;
  int m_ier = 0;
  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit m_pend();
    return ((m_ier & 1) != 0 && m_q.size() != 0) || ((m_ier & 2) != 0);
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      8'h00: return "R3";
      8'h40: return "R9";
      8'h44: return "R2";
      8'h48: return "R4";
      8'h54: return "R6";
      8'h64: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic longint exp_read(input int a);
    int n;
    n = m_q.size();
    case (a)
      8'h00: return m_pend() ? 1 : 0;
      8'h04: return 1;
      8'h40: return m_slot[m_head];
      8'h44: return 'hC0 + m_ier;
      8'h48: return 'hC0 + (n != 0 ? 4 : 2) + (m_pend() ? 0 : 1);
      8'h54: return 'h60 + (n != 0 ? 1 : 0);
      8'h60: return 3;
      8'h64: return (n != 0) ? ('h30F + (longint'(n) << 16)) : 'h30E;
      default: return 0;
    endcase
  endfunction

  // one bus cycle; entered and left just after a falling edge
  task automatic cyc(input bit s, input bit w, input int a, input int d,
                     input bit v, input int b);
    bit flush, exp_rdy, is_pop;
    int slot;
    bus_sel = s; bus_wr = w; bus_addr = 8'(a); bus_wdata = d;
    rx_valid = v; rx_data = 8'(b);
    #1;
    flush   = s && w && a == 8'h48 && (d & 2) != 0;
    exp_rdy = (m_q.size() < D) && !flush;
    check(rx_ready == exp_rdy, flush ? "R5" : "R10", rx_ready, exp_rdy);
    check(irq == m_pend(), "R3", irq, m_pend());
    check(tx_strobe == (s && w && a == 8'h40), "R11", tx_strobe, s && w && a == 8'h40);
    if (s && w && a == 8'h40) check(tx_data == 8'(d), "R11", tx_data, d & 'hFF);
    if (s && !w && (a != 8'h40 || m_known[m_head]))
      check(bus_rdata == 32'(exp_read(a)), tag_of(a), bus_rdata, exp_read(a));
    @(posedge clk);
    is_pop = s && !w && a == 8'h40 && m_q.size() != 0;
    if (v && exp_rdy) begin
      slot = (m_head + m_q.size()) % D;
      m_slot[slot] = b & 'hFF; m_known[slot] = 1'b1;
      m_q.push_back(b & 'hFF);
    end
    if (is_pop) begin
      void'(m_q.pop_front());
      m_head = (m_head + 1) % D;
    end
    if (s && w && a == 8'h44) m_ier = d & 3;
    if (flush) m_q.delete();
    @(negedge clk);
    bus_sel = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic rd(input int a);
    cyc(1, 0, a, 0, 0, 0);
  endtask
  task automatic wr(input int a, input int d);
    cyc(1, 1, a, d, 0, 0);
  endtask
  task automatic push(input int b);
    cyc(0, 0, 0, 0, 1, b);
  endtask

  task automatic read_all();
    foreach (ofs_list[i]) rd(ofs_list[i]);
  endtask
  int ofs_list[] = '{'h00, 'h04, 'h44, 'h48, 'h4C, 'h50, 'h54, 'h58, 'h5C,
                     'h60, 'h64, 'h68, 'h6C, 'h41, 'hFC};

  initial begin
    #(200000 * 8);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state after reset
    check(irq == 1'b0, "R1", irq, 0);
    check(rx_ready == 1'b1, "R1", rx_ready, 1);
    read_all();
    // R2 / R3: enables
    wr('h44, 'hFF);
    rd('h44); rd('h00); rd('h48);
    wr('h44, 0);
    // R10: fill queue
    push('h11); push('h22); push('h33);
    read_all();
    wr('h44, 1);   // R3 receive source
    rd('h00); rd('h48);
    // R9: drain
    rd('h40); rd('h40); rd('h40);
    rd('h00);
    rd('h40);      // empty read, stale slot, no state change (R9)
    rd('h64);
    // R10: full and a rejected byte
    push('hA1); push('hA2); push('hA3); push('hA4); push('hA5);
    rd('h64); rd('h54);
    // R12: push and pop together (full, so push refused)
    cyc(1, 0, 'h40, 0, 1, 'hB0);
    cyc(1, 0, 'h40, 0, 1, 'hB1); // count 3, push and pop at once
    rd('h64);
    rd('h40); rd('h40); rd('h40); rd('h40);
    // R5: flush with a byte offered in the same cycle
    push('hC1); push('hC2);
    cyc(1, 1, 'h48, 2, 1, 'hC3);
    rd('h64); rd('h48);
    wr('h48, 1);  // bit 1 clear: no flush
    push('hD1);
    wr('h48, 4); rd('h64);
    // R8: ignored writes
    foreach (ofs_list[i]) if (ofs_list[i] != 'h44 && ofs_list[i] != 'h48) wr(ofs_list[i], -1);
    read_all();
    // R11: transmit strobe
    wr('h40, 'h5A); wr('h40, 'h1A5); rd('h40);
    // R1: reset mid-stream
    wr('h44, 3); push('hEE);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    m_q.delete(); m_head = 0; m_ier = 0;
    check(irq == 1'b0, "R1", irq, 0);
    rd('h44); rd('h64);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule